// File: doc/BRIEF.md
# Calculator Arithmetic and Shift Unit

This block is the execution core of a small calculator. Each cycle it may be handed one complete operation: a start strobe, a 4-bit command and two 32-bit unsigned operands. One clock edge later it presents a registered result word, a 2-bit response code and a valid strobe.

It supports four operations: unsigned addition, unsigned subtraction, logical left shift and logical right shift. A sum that does not fit and a difference that would go below zero are reported as errors and do not wrap. Any command outside the defined set is rejected without running anything. A no-op command, or a cycle with no start, leaves the outputs silent.

Top module: `calc_alu`

## Requirements
- R1: While reset is high, and in the cycle after it is released, `res_valid` is 0, `res_code` is 00 and `res_data` is 0, whatever the other inputs are.
- R2: Command 0001 (add) with a true sum below 2^32 gives, one cycle after start, `res_valid`=1, `res_code`=01 and `res_data` equal to the sum.
- R3: Command 0001 with a true sum of 2^32 or more gives `res_code`=10, `res_valid`=1 and `res_data`=0. Whenever `res_code` is not 01, `res_data` is 0.
- R4: Command 0010 (subtract) with `op_b` <= `op_a` gives `res_code`=01 and `res_data`=`op_a`-`op_b`. Equal operands give 0 with code 01.
- R5: Command 0010 with `op_b` > `op_a` gives `res_code`=10 (underflow), `res_valid`=1 and `res_data`=0.
- R6: Command 0101 gives code 01 and `op_a` shifted left by `op_b[4:0]`, with zeros shifted in. Bits [31:5] of `op_b` have no effect.
- R7: Command 0110 gives code 01 and `op_a` shifted right by `op_b[4:0]`, with zeros shifted in. Bits [31:5] of `op_b` have no effect.
- R8: A shift of either direction with `op_b[4:0]`=0 returns `op_a` unchanged.
- R9: Every command value other than 0000, 0001, 0010, 0101 and 0110 gives `res_code`=10, `res_valid`=1 and `res_data`=0.
- R10: Command 0000 (no-op) with start gives `res_code`=00, `res_valid`=0 and `res_data`=0.
- R11: A cycle with `start`=0 gives `res_valid`=0, `res_code`=00 and `res_data`=0 on the next cycle, whatever the command and operands are.
- R12: `res_code` is never 11, and `res_valid` is 1 exactly when `res_code` is not 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Accept the operation presented this cycle |
| cmd | input | 4 | Operation code |
| op_a | input | 32 | First operand (value to be shifted for shifts) |
| op_b | input | 32 | Second operand (shift amount in bits [4:0]) |
| res_valid | output | 1 | Result strobe, one cycle after start |
| res_code | output | 2 | 00 none, 01 success, 10 error |
| res_data | output | 32 | Result word, zero unless code is 01 |

## Verification
Directed vectors cover both sides of each range boundary: a sum of exactly 2^32-1 against 2^32, and subtraction with equal operands against operands one apart in each direction. These separate a correct carry or borrow test from one that is off by one. Shifts are applied with amounts 0, 1 and 31, and with junk in the upper bits of `op_b`. This separates correct masking and zero fill from wrap-around, from use of the full operand, and from a shift by zero that returns 0. All eleven undefined command codes, no-op starts and idle cycles with busy operands confirm that nothing leaks to the outputs. A long stream of random commands and operands, including back-to-back starts, is then checked against an independent reference model.

// File: rtl/calc_pkg.sv
package calc_pkg;

    localparam int CMD_W  = 4;
    localparam int CODE_W = 2;

    typedef enum logic [CMD_W-1:0] {
        CMD_NOP = 4'b0000,
        CMD_ADD = 4'b0001,
        CMD_SUB = 4'b0010,
        CMD_SHL = 4'b0101,
        CMD_SHR = 4'b0110
    } calc_cmd_e;

    typedef enum logic [CODE_W-1:0] {
        CODE_NONE = 2'b00,
        CODE_OK   = 2'b01,
        CODE_ERR  = 2'b10
    } calc_code_e;

    typedef enum logic [2:0] {
        OPK_NONE,
        OPK_ADD,
        OPK_SUB,
        OPK_SHL,
        OPK_SHR,
        OPK_BAD
    } op_kind_e;

    typedef struct packed {
        op_kind_e kind;
        logic     arith;
        logic     subtract;
        logic     shift;
        logic     left;
    } dec_t;

    function automatic dec_t decode_cmd(input logic [CMD_W-1:0] c);
        dec_t d;
        d = '{kind: OPK_BAD, arith: 1'b0, subtract: 1'b0, shift: 1'b0, left: 1'b0};
        case (c)
            CMD_NOP: d.kind = OPK_NONE;
            CMD_ADD: begin d.kind = OPK_ADD; d.arith = 1'b1; end
            CMD_SUB: begin d.kind = OPK_SUB; d.arith = 1'b1; d.subtract = 1'b1; end
            CMD_SHL: begin d.kind = OPK_SHL; d.shift = 1'b1; d.left = 1'b1; end
            CMD_SHR: begin d.kind = OPK_SHR; d.shift = 1'b1; end
            default: d.kind = OPK_BAD;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/calc_cmd_decode.sv
module calc_cmd_decode
    import calc_pkg::*;
(
    input  logic [CMD_W-1:0] cmd,
    output dec_t             dec
);
    always_comb begin
        dec = decode_cmd(cmd);
    end
endmodule

// File: rtl/calc_addsub.sv
module calc_addsub #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              subtract,
    output logic [DATA_W-1:0] y,
    output logic              range_err
);
    localparam int EXT_W = DATA_W + 1;

    logic [EXT_W-1:0] sum_ext;
    logic [EXT_W-1:0] diff_ext;

    always_comb begin
        sum_ext  = {1'b0, a} + {1'b0, b};
        diff_ext = {1'b0, a} - {1'b0, b};
        if (subtract) begin
            y         = diff_ext[DATA_W-1:0];
            range_err = diff_ext[DATA_W];
        end else begin
            y         = sum_ext[DATA_W-1:0];
            range_err = sum_ext[DATA_W];
        end
    end
endmodule

// File: rtl/calc_shifter.sv
module calc_shifter #(
    parameter int DATA_W = 32,
    parameter int SH_W   = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] val,
    input  logic [SH_W-1:0]   amt,
    input  logic              left,
    output logic [DATA_W-1:0] y
);
    logic [DATA_W-1:0] stg [0:SH_W];

    assign stg[0] = val;

    for (genvar k = 0; k < SH_W; k++) begin : g_stage
        localparam int DIST = 1 << k;
        logic [DATA_W-1:0] moved;
        assign moved      = left ? (stg[k] << DIST) : (stg[k] >> DIST);
        assign stg[k+1]   = amt[k] ? moved : stg[k];
    end

    assign y = stg[SH_W];
endmodule

// File: rtl/calc_alu.sv
module calc_alu
    import calc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [3:0]        cmd,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    output logic              res_valid,
    output logic [1:0]        res_code,
    output logic [DATA_W-1:0] res_data
);
    localparam int SH_W = $clog2(DATA_W);

    dec_t              dec;
    logic [DATA_W-1:0] arith_y;
    logic              arith_err;
    logic [DATA_W-1:0] shift_y;
    calc_code_e        nxt_code;
    logic [DATA_W-1:0] nxt_data;

    calc_cmd_decode u_dec (
        .cmd (cmd),
        .dec (dec)
    );

    calc_addsub #(.DATA_W(DATA_W)) u_addsub (
        .a         (op_a),
        .b         (op_b),
        .subtract  (dec.subtract),
        .y         (arith_y),
        .range_err (arith_err)
    );

    calc_shifter #(.DATA_W(DATA_W), .SH_W(SH_W)) u_shift (
        .val  (op_a),
        .amt  (op_b[SH_W-1:0]),
        .left (dec.left),
        .y    (shift_y)
    );

    always_comb begin
        nxt_code = CODE_NONE;
        nxt_data = '0;
        case (dec.kind)
            OPK_ADD, OPK_SUB: begin
                if (arith_err) begin
                    nxt_code = CODE_ERR;
                end else begin
                    nxt_code = CODE_OK;
                    nxt_data = arith_y;
                end
            end
            OPK_SHL, OPK_SHR: begin
                nxt_code = CODE_OK;
                nxt_data = shift_y;
            end
            OPK_BAD:  nxt_code = CODE_ERR;
            default:  nxt_code = CODE_NONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !start) begin
            res_valid <= 1'b0;
            res_code  <= CODE_NONE;
            res_data  <= '0;
        end else begin
            res_valid <= (nxt_code != CODE_NONE);
            res_code  <= nxt_code;
            res_data  <= nxt_data;
        end
    end
endmodule

// File: rtl/calc_alu_chk.sv
module calc_alu_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [3:0]        cmd,
    input logic [DATA_W-1:0] op_a,
    input logic [DATA_W-1:0] op_b,
    input logic              res_valid,
    input logic [1:0]        res_code,
    input logic [DATA_W-1:0] res_data
);
    localparam int SH_W = $clog2(DATA_W);

    logic known_cmd;
    logic [DATA_W:0] wide_sum;
    assign known_cmd = (cmd == 4'd0) || (cmd == 4'd1) || (cmd == 4'd2) ||
                       (cmd == 4'd5) || (cmd == 4'd6);
    assign wide_sum  = {1'b0, op_a} + {1'b0, op_b};

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!res_valid && res_code == 2'b00 && res_data == '0)) else $error("reset"); // R1
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) (start && cmd == 4'd1 && wide_sum[DATA_W]) |=> (res_code == 2'b10)) else $error("ovf"); // R3
    AST_ERR_DATA_ZERO: assert property (@(posedge clk) disable iff (rst) (res_code != 2'b01) |-> (res_data == '0)) else $error("data"); // R3
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst) (start && cmd == 4'd2 && op_b > op_a) |=> (res_code == 2'b10)) else $error("udf"); // R5
    AST_SHIFT_ZERO: assert property (@(posedge clk) disable iff (rst) (start && (cmd == 4'd5 || cmd == 4'd6) && op_b[SH_W-1:0] == '0) |=> (res_data == $past(op_a))) else $error("sh0"); // R8
    AST_BAD_CMD: assert property (@(posedge clk) disable iff (rst) (start && !known_cmd) |=> (res_code == 2'b10 && res_valid)) else $error("bad"); // R9
    AST_NOP_SILENT: assert property (@(posedge clk) disable iff (rst) (start && cmd == 4'd0) |=> (!res_valid && res_code == 2'b00)) else $error("nop"); // R10
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst) !start |=> (!res_valid && res_code == 2'b00 && res_data == '0)) else $error("idle"); // R11
    AST_NO_CODE3: assert property (@(posedge clk) disable iff (rst) res_code != 2'b11) else $error("code3"); // R12
    AST_VALID_CODE: assert property (@(posedge clk) disable iff (rst) res_valid == (res_code != 2'b00)) else $error("vld"); // R12
endmodule

bind calc_alu calc_alu_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .cmd       (cmd),
    .op_a      (op_a),
    .op_b      (op_b),
    .res_valid (res_valid),
    .res_code  (res_code),
    .res_data  (res_data)
);

// File: tb/tb_calc_alu.sv
module tb_calc_alu;
    localparam int CLK_PERIOD = 10;
    localparam int DW         = 32;
    localparam int WATCHDOG   = 200000;

    typedef struct {
        logic          vld;
        logic [1:0]    code;
        logic [DW-1:0] data;
        string         req;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [3:0]    cmd = '0;
    logic [DW-1:0] op_a = '0;
    logic [DW-1:0] op_b = '0;
    logic          res_valid;
    logic [1:0]    res_code;
    logic [DW-1:0] res_data;

    int   n_vec  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;
    exp_t expq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    calc_alu #(.DATA_W(DW)) dut (
        .clk(clk), .rst(rst), .start(start), .cmd(cmd),
        .op_a(op_a), .op_b(op_b),
        .res_valid(res_valid), .res_code(res_code), .res_data(res_data)
    );

    function automatic exp_t model(input logic st, input logic [3:0] c,
                                   input logic [DW-1:0] a, input logic [DW-1:0] b);
        exp_t e;
        logic [DW:0] s;
        e.vld = 1'b1; e.code = 2'b01; e.data = '0;
        if (!st) begin
            e.vld = 1'b0; e.code = 2'b00; e.req = "R11";
            return e;
        end
        case (c)
            4'd0: begin e.vld = 1'b0; e.code = 2'b00; e.req = "R10"; end
            4'd1: begin
                s = {1'b0, a} + {1'b0, b};
                if (s[DW]) begin e.code = 2'b10; e.req = "R3"; end
                else begin e.data = s[DW-1:0]; e.req = "R2"; end
            end
            4'd2: begin
                if (b > a) begin e.code = 2'b10; e.req = "R5"; end
                else begin e.data = a - b; e.req = "R4"; end
            end
            4'd5: begin e.data = a << b[4:0]; e.req = (b[4:0] == 0) ? "R8" : "R6"; end
            4'd6: begin e.data = a >> b[4:0]; e.req = (b[4:0] == 0) ? "R8" : "R7"; end
            default: begin e.code = 2'b10; e.req = "R9"; end
        endcase
        return e;
    endfunction

    task automatic drive(input logic st, input logic [3:0] c,
                         input logic [DW-1:0] a, input logic [DW-1:0] b);
        @(negedge clk);
        start = st; cmd = c; op_a = a; op_b = b;
        expq.push_back(model(st, c, a, b));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    endtask

    // monitor: one expected item per clock edge after it was driven
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (expq.size() > 0) begin
            exp_t e;
            e = expq.pop_front();
            n_vec++;
            if (res_valid !== e.vld || res_code !== e.code || res_data !== e.data) begin
                n_fail++;
                $display("FAIL %s: got vld=%0b code=%b data=%h, expected vld=%0b code=%b data=%h",
                         e.req, res_valid, res_code, res_data, e.vld, e.code, e.data);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        n_fail++;
        $display("FAIL watchdog: got no completion, expected finish before %0d cycles", WATCHDOG);
        finish_run();
    end

    initial begin
        // R1: reset dominates a live start
        start = 1'b1; cmd = 4'd1; op_a = 32'h5; op_b = 32'h7;
        repeat (4) @(negedge clk);
        n_vec++;
        if (res_valid !== 1'b0 || res_code !== 2'b00 || res_data !== '0) begin
            n_fail++;
            $display("FAIL R1: got vld=%0b code=%b data=%h, expected 0 00 0", res_valid, res_code, res_data);
        end
        rst = 1'b0; start = 1'b0;
        @(negedge clk);
        n_vec++;
        if (res_valid !== 1'b0 || res_code !== 2'b00 || res_data !== '0) begin
            n_fail++;
            $display("FAIL R1: got vld=%0b code=%b data=%h after release, expected 0 00 0", res_valid, res_code, res_data);
        end

        // R2 / R3 add boundaries
        drive(1, 4'd1, 32'd3, 32'd4);
        drive(1, 4'd1, 32'hFFFF_FFFE, 32'd1);
        drive(1, 4'd1, 32'hFFFF_FFFF, 32'd1);
        drive(1, 4'd1, 32'h8000_0000, 32'h8000_0000);
        drive(1, 4'd1, 32'h08EA_14DC, 32'h036B_A248);
        // R4 / R5 sub boundaries
        drive(1, 4'd2, 32'd100, 32'd100);
        drive(1, 4'd2, 32'd101, 32'd100);
        drive(1, 4'd2, 32'd100, 32'd101);
        drive(1, 4'd2, 32'd0, 32'hFFFF_FFFF);
        // R6 / R7 / R8 shifts
        drive(1, 4'd5, 32'h8000_0001, 32'd1);
        drive(1, 4'd5, 32'h0000_0003, 32'd31);
        drive(1, 4'd5, 32'h0000_00F0, 32'hFFFF_FFE4);
        drive(1, 4'd6, 32'h8000_0001, 32'd1);
        drive(1, 4'd6, 32'hF000_0000, 32'd31);
        drive(1, 4'd6, 32'hABCD_1234, 32'h0000_0128);
        drive(1, 4'd5, 32'hDEAD_BEEF, 32'd0);
        drive(1, 4'd6, 32'hDEAD_BEEF, 32'hFFFF_FFE0);
        // R9 every undefined code
        for (int c = 0; c < 16; c++) begin
            if (!(c == 0 || c == 1 || c == 2 || c == 5 || c == 6))
                drive(1, 4'(c), 32'h1234_5678, 32'h1);
        end
        // R10 no-op, R11 idle with busy inputs
        drive(1, 4'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        drive(0, 4'd1, 32'h1, 32'h2);
        drive(0, 4'd9, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        drive(1, 4'd1, 32'd10, 32'd20);
        drive(0, 4'd5, 32'h1, 32'h1);
        // random stream, R12 checked through every compare
        for (int i = 0; i < 400; i++) begin
            logic [3:0]    rc;
            logic [DW-1:0] ra, rb;
            rc = (i % 3 == 0) ? 4'($urandom_range(0, 15)) : 4'({1'b0, 3'($urandom_range(0, 7))});
            ra = $urandom();
            rb = (i % 4 == 0) ? ra : $urandom();
            if (i % 5 == 0) ra = ra >> 4;
            drive((i % 7) != 3, rc, ra, rb);
        end
        drive(0, 4'd0, '0, '0);
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule